// File: doc/BRIEF.md
# Display Bus Serial Command Transmitter

This block turns a stream of bytes, each tagged as a command or as data, into serial words for a display controller on a write-only serial link. It drives the chip select, the serial clock, the serial data line, a dedicated data/command line and an active-low panel reset. It never samples a return line.

A static framing selector picks one of three word shapes:
- a 9-bit word, with the data/command flag sent ahead of the byte;
- a 16-bit word, with seven zero padding bits, then the flag, then the byte;
- a plain 8-bit word, with the flag carried on the separate line.

The first two let the link run with three wires, because the flag travels inside the word. The serial clock comes from dividing the system clock by an even ratio. Bytes offered back to back share one chip-select window. A reset request pulls the panel reset low for a programmable number of cycles, and no input is taken during that time.

Top module: `dbus_serial_tx`

## Requirements
- R1: After `rst_n` is released, `cs_n` is 1, `sclk` is 0, `panel_rst_n` is 1 and `in_ready` is 1.
- R2: With `frame_mode` = 0, each byte is sent as 9 bits: the flag (1 = data, 0 = command) first, then bit 7 down to bit 0. A command word therefore starts with 0.
- R3: With `frame_mode` = 1, each byte is sent as 16 bits: seven bits of 0, then the flag, then bit 7 down to bit 0.
- R4: With `frame_mode` = 2 or 3, each byte is sent as 8 bits, bit 7 first. `dcx` carries the flag, is set before the first rising `sclk` edge of that byte, and holds until the byte ends. `dcx` also follows the flag in the other modes.
- R5: `sdo` changes only while `sclk` falls or is low, never at a rising `sclk` edge, so the receiver can sample on the rising edge.
- R6: `sclk` is low whenever `cs_n` is high.
- R7: While `in_valid` stays high at the end of each word, the following bytes go out in the same `cs_n` low window. `cs_n` returns high at the final falling `sclk` edge.
- R8: One `sclk` period lasts 2 × `half_div` system clocks. A `half_div` of 0 acts as 1.
- R9: `in_ready` is high only while the shifter is idle or in the cycle that ends the last bit of the current word. It is low during the rest of a word.
- R10: A one-cycle `panel_rst_req` (sampled high at a clock edge) drives `panel_rst_n` low for `rst_len` cycles starting at the next cycle. An `rst_len` of 0 acts as 1. `in_ready` is low in the request cycle and throughout that window, so no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| frame_mode | input | 2 | Framing select: 0 = 9-bit, 1 = 16-bit, 2/3 = 8-bit with separate flag line |
| half_div | input | DIV_W | System clocks per half serial-clock period |
| rst_len | input | RST_W | Panel reset low time in cycles |
| panel_rst_req | input | 1 | Request a panel reset pulse |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_ready | output | 1 | Byte accepted at a clock edge where valid and ready are both high |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out, MSB first |
| dcx | output | 1 | Separate data/command line |
| panel_rst_n | output | 1 | Panel reset, active low |

## Verification
The bench sends single bytes through every framing with both flag values, varying the divide ratio between bytes. Word length separates the 9-bit and 16-bit framings, which carry the same numeric value. The flag bit separates command words from data words, and the period measured between rising edges checks the divider.

Back-to-back bursts in the 8-bit and 9-bit modes show that chip select stays low across bytes and that the flag line follows each byte. Directed cases then cover a divide ratio of zero, `in_ready` during a word, and a panel reset pulse raised while a byte is waiting, which must not start a transfer.

// File: rtl/dbus_tx_pkg.sv
// Package dbus_tx_pkg
// Shared framing codes and the word builder for the serial transmitter.
// Assumes words are at most 16 bits and are held left-justified for MSB-first shifting.
package dbus_tx_pkg;

    localparam int WORD_W = 16;
    localparam int LEN_W  = 5;

    localparam logic [1:0] FRM_NINE    = 2'd0;
    localparam logic [1:0] FRM_SIXTEEN = 2'd1;

    typedef struct packed {
        logic [WORD_W-1:0] bits;  // left-justified word, MSB goes out first
        logic [LEN_W-1:0]  len;   // number of bits in the word
    } frame_t;

    // Build the on-wire word for one byte in the selected framing.
    function automatic frame_t build_frame(input logic [1:0] mode,
                                           input logic       is_data,
                                           input logic [7:0] b);
        frame_t f;
        case (mode)
            FRM_NINE: begin
                f.bits = {is_data, b, 7'b0};
                f.len  = LEN_W'(9);
            end
            FRM_SIXTEEN: begin
                f.bits = {7'b0, is_data, b};
                f.len  = LEN_W'(16);
            end
            default: begin
                f.bits = {b, 8'b0};
                f.len  = LEN_W'(8);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dbus_tx_clkdiv.sv
// Module dbus_tx_clkdiv
// Emits a one-cycle tick every half serial-clock period while run is high.
// Assumes half_div is static during a transfer; 0 is treated as 1.
// The counter restarts from zero whenever run is low or a tick fires.
module dbus_tx_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;

    // Terminal count for one half period.
    assign lim_m1 = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick   = run && (cnt == lim_m1);

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dbus_tx_rstgen.sv
// Module dbus_tx_rstgen
// Drives the active-low panel reset for a programmable number of cycles after a request.
// Assumes a request reloads the counter; a length of 0 is treated as 1.
module dbus_tx_rstgen #(
    parameter int RST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [RST_W-1:0] len,
    output logic             busy,
    output logic             panel_rst_n
);

    logic [RST_W-1:0] cnt;

    // Countdown of the remaining reset-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (req) begin
            cnt <= (len == '0) ? RST_W'(1) : len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign panel_rst_n = (cnt == '0);
    assign busy        = req || (cnt != '0);

    // R10
    rst_low_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !panel_rst_n);

    // R10
    rst_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_rst_n) |-> $past(req));

endmodule

// File: rtl/dbus_tx_shifter.sv
// Module dbus_tx_shifter
// Loads one framed byte at a time and shifts it MSB first.
// Data changes on the falling serial-clock edge; chip select spans back-to-back bytes.
// Assumes tick comes from a divider that runs only while run is high.
module dbus_tx_shifter
    import dbus_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       hold_off,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    output logic       in_ready,
    input  logic       tick,
    output logic       run,
    output logic       cs_n,
    output logic       sclk,
    output logic       sdo,
    output logic       dcx
);

    typedef enum logic {SH_IDLE, SH_SHIFT} sh_state_t;

    sh_state_t         state;
    logic [WORD_W-1:0] sreg;
    logic [LEN_W-1:0]  bitcnt;
    logic              last_fall;
    logic              accept;
    frame_t            word;

    // Handshake and framing of the offered byte.
    assign run       = (state == SH_SHIFT);
    assign last_fall = run && tick && sclk && (bitcnt == '0);
    assign in_ready  = !hold_off && ((state == SH_IDLE) || last_fall);
    assign accept    = in_valid && in_ready;
    assign word      = build_frame(mode, in_is_data, in_byte);

    // Shift engine: load, toggle the serial clock and advance bits on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            sdo    <= 1'b0;
            dcx    <= 1'b0;
            sreg   <= '0;
            bitcnt <= '0;
        end else if (accept) begin
            state  <= SH_SHIFT;
            cs_n   <= 1'b0;
            sclk   <= 1'b0;
            sdo    <= word.bits[WORD_W-1];
            sreg   <= word.bits << 1;
            dcx    <= in_is_data;
            bitcnt <= word.len - 1'b1;
        end else if (run && tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
            end else begin
                sclk <= 1'b0;
                if (bitcnt == '0) begin
                    state <= SH_IDLE;
                    cs_n  <= 1'b1;
                    sdo   <= 1'b0;
                end else begin
                    sdo    <= sreg[WORD_W-1];
                    sreg   <= sreg << 1;
                    bitcnt <= bitcnt - 1'b1;
                end
            end
        end
    end

    // R6
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5
    sdo_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> ($stable(sdo) && $stable(dcx)));

    // R4
    dcx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$past(accept)) |-> $stable(dcx));

    // R9
    ready_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |-> !in_ready);

endmodule

// File: rtl/dbus_serial_tx.sv
// Module dbus_serial_tx
// Top of the write-only display bus serial transmitter.
// Ties the divider, shifter and panel reset generator together.
// Assumes frame_mode and half_div are static while bytes are in flight.
module dbus_serial_tx #(
    parameter int DIV_W = 8,
    parameter int RST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       frame_mode,
    input  logic [DIV_W-1:0] half_div,
    input  logic [RST_W-1:0] rst_len,
    input  logic             panel_rst_req,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_is_data,
    output logic             in_ready,
    output logic             cs_n,
    output logic             sclk,
    output logic             sdo,
    output logic             dcx,
    output logic             panel_rst_n
);

    logic tick;
    logic run;
    logic rst_busy;

    dbus_tx_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    dbus_tx_rstgen #(.RST_W(RST_W)) u_rstgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (panel_rst_req),
        .len         (rst_len),
        .busy        (rst_busy),
        .panel_rst_n (panel_rst_n)
    );

    dbus_tx_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (frame_mode),
        .hold_off   (rst_busy),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_is_data (in_is_data),
        .in_ready   (in_ready),
        .tick       (tick),
        .run        (run),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdo        (sdo),
        .dcx        (dcx)
    );

    // R10
    no_accept_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> !in_ready);

endmodule

// File: tb/dbus_serial_tx_bench.sv
// Bench for dbus_serial_tx.
// Walks a vector table of single bytes, then runs directed tests.
module dbus_serial_tx_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] md;
        logic       d;
        logic [7:0] b;
        logic [3:0] dh;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{2'd0, 1'b0, 8'h2A, 4'd1},
        '{2'd0, 1'b1, 8'hA5, 4'd2},
        '{2'd1, 1'b0, 8'h3C, 4'd3},
        '{2'd1, 1'b1, 8'hFF, 4'd1},
        '{2'd2, 1'b0, 8'h81, 4'd4},
        '{2'd2, 1'b1, 8'h5E, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  frame_mode = 2'd0;
    logic [7:0]  half_div = 8'd1;
    logic [15:0] rst_len = 16'd1;
    logic        panel_rst_req = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_is_data = 1'b0;
    logic        in_ready, cs_n, sclk, sdo, dcx, panel_rst_n;

    int checks = 0;
    int errors = 0;

    // Monitor state, written only by the monitor process.
    logic [63:0] cap = '0;
    logic [63:0] dlog = '0;
    int          ncap = 0;
    int          crise = 0;
    int          per = 0;
    int          last_rise = 0;
    int          cyc = 0;
    logic        sclk_q = 1'b0;
    logic        cs_q = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbus_serial_tx u_dbus_serial_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_mode    (frame_mode),
        .half_div      (half_div),
        .rst_len       (rst_len),
        .panel_rst_req (panel_rst_req),
        .in_valid      (in_valid),
        .in_byte       (in_byte),
        .in_is_data    (in_is_data),
        .in_ready      (in_ready),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .sdo           (sdo),
        .dcx           (dcx),
        .panel_rst_n   (panel_rst_n)
    );

    // Serial monitor: capture sdo and dcx at each rising sclk, count cs_n rises and measure the period.
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        sclk_q <= sclk;
        cs_q   <= cs_n;
        if (sclk && !sclk_q && !cs_n) begin
            cap       <= {cap[62:0], sdo};
            dlog      <= {dlog[62:0], dcx};
            ncap      <= ncap + 1;
            per       <= cyc - last_rise;
            last_rise <= cyc;
        end
        if (cs_n && !cs_q) crise <= crise + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Offer one byte and return at the negedge following its acceptance; valid stays high.
    task automatic put(input logic d, input logic [7:0] b);
        in_valid   = 1'b1;
        in_is_data = d;
        in_byte    = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (!cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [63:0] mask(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    initial begin
        int b0, c0, n;
        logic [15:0] expw;
        int          len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {63'b0, cs_n}, 64'd1);
        chk("R1 sclk", {63'b0, sclk}, 64'd0);
        chk("R1 panel_rst_n", {63'b0, panel_rst_n}, 64'd1);
        chk("R1 in_ready", {63'b0, in_ready}, 64'd1);

        // Table walk: single bytes in every framing (R2, R3, R4, R8)
        for (int i = 0; i < 6; i++) begin
            frame_mode = VT[i].md;
            half_div   = {4'b0, VT[i].dh};
            b0 = ncap;
            put(VT[i].d, VT[i].b);
            in_valid = 1'b0;
            wait_idle();
            case (VT[i].md)
                2'd0:    begin expw = {7'b0, VT[i].d, VT[i].b}; len = 9;  end
                2'd1:    begin expw = {7'b0, VT[i].d, VT[i].b}; len = 16; end
                default: begin expw = {8'b0, VT[i].b};          len = 8;  end
            endcase
            chk(VT[i].md == 2'd0 ? "R2 bit count" : VT[i].md == 2'd1 ? "R3 bit count" : "R4 bit count",
                64'(ncap - b0), 64'(len));
            chk(VT[i].md == 2'd0 ? "R2 word" : VT[i].md == 2'd1 ? "R3 word" : "R4 word",
                cap & mask(len), {48'b0, expw});
            chk("R8 period", 64'(per), 64'(2 * VT[i].dh));
            if (VT[i].md == 2'd2)
                chk("R4 dcx held", dlog & mask(8), VT[i].d ? 64'hFF : 64'h00);
        end

        // R7 burst in 8-bit mode: one cs window, flag line per byte
        frame_mode = 2'd2; half_div = 8'd1;
        b0 = ncap; c0 = crise;
        put(1'b0, 8'h11); put(1'b1, 8'h22); put(1'b1, 8'h33);
        in_valid = 1'b0;
        wait_idle();
        chk("R7 burst bits", 64'(ncap - b0), 64'd24);
        chk("R7 burst data", cap & mask(24), 64'h112233);
        chk("R4 burst dcx", dlog & mask(24), 64'h00FFFF);
        chk("R7 single cs window", 64'(crise - c0), 64'd1);

        // R7 burst in 9-bit mode
        frame_mode = 2'd0; half_div = 8'd2;
        b0 = ncap; c0 = crise;
        put(1'b0, 8'hC3); put(1'b1, 8'h7E);
        in_valid = 1'b0;
        wait_idle();
        chk("R7 nine-bit burst", cap & mask(18), {46'b0, 1'b0, 8'hC3, 1'b1, 8'h7E});
        chk("R7 nine-bit cs window", 64'(crise - c0), 64'd1);

        // R8 divisor zero acts as one; R9 ready low mid word
        frame_mode = 2'd2; half_div = 8'd0;
        put(1'b1, 8'hF0);
        in_valid = 1'b0;
        wait_idle();
        chk("R8 zero divisor period", 64'(per), 64'd2);
        half_div = 8'd4;
        put(1'b0, 8'h0F);
        in_valid = 1'b0;
        chk("R9 ready low mid word", {63'b0, in_ready}, 64'd0);
        chk("R6 cs low during word", {63'b0, cs_n}, 64'd0);
        wait_idle();
        chk("R9 ready high idle", {63'b0, in_ready}, 64'd1);

        // R10 panel reset pulse with a byte waiting
        rst_len = 16'd5; half_div = 8'd1;
        c0 = crise;
        in_valid = 1'b1; in_byte = 8'hAA; in_is_data = 1'b1;
        panel_rst_req = 1'b1;
        @(negedge clk);
        panel_rst_req = 1'b0;
        n = 0;
        while (!panel_rst_n) begin
            n++;
            chk("R10 ready low in reset", {63'b0, in_ready}, 64'd0);
            chk("R10 no transfer in reset", {63'b0, cs_n}, 64'd1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R10 reset low cycles", 64'(n), 64'd5);
        @(negedge clk);
        chk("R10 still idle after", {63'b0, cs_n}, 64'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule